// File: doc/BRIEF.md
# Two-Thread Allocation Arbiter with Threading-Mode Control

This block picks, on every cycle, which of two hardware threads may allocate micro-ops into a shared set of back-end buffers. A thread can go only when it has work queued, is below its entry limit and is awake. When both can go, the grant alternates between them. When only one can go, that thread receives the grant whatever the turn says. The grant is combinational from the current inputs, so allocation can use it in the same cycle.

Next to the arbiter sits a small mode machine. It keeps track of which threads are awake: both (multi-thread mode), one (single-thread mode for thread 0 or thread 1) or none (low power). Halt events put threads to sleep and interrupt events wake them. The mode sets the per-thread entry limits. With both threads awake the buffer is split in half. With one thread awake the whole buffer goes to that thread. In low power no thread may allocate.

Top module: `thread_alloc_arb`

## Requirements
- R1: `grant` has at most one bit set. Bit 0 grants thread 0 and bit 1 grants thread 1.
- R2: A thread is eligible only when its queue-empty flag is 0, it is awake in the current mode, and its occupancy is strictly below its limit. Only an eligible thread is granted.
- R3: When both threads are eligible, the grant goes to the thread holding the turn. When exactly one is eligible, that thread is granted regardless of the turn. After each grant the turn passes to the other thread. With no grant the turn is held.
- R4: The limits follow the mode. Multi-thread: ENTRIES/2 each (16/16). Single-thread 0: ENTRIES/0 (32/0). Single-thread 1: 0/ENTRIES (0/32). Low power: 0/0.
- R5: `mode` is encoded as multi-thread=0, single-thread-0=1, single-thread-1=2, low power=3. Reset gives multi-thread mode with the turn at thread 0. A mode change is visible on the cycle after the event that caused it.
- R6: In multi-thread mode, halt[1] alone moves to single-thread-0, halt[0] alone moves to single-thread-1, and both together move to low power.
- R7: In a single-thread mode, a halt by the awake thread moves to low power. A halt by the already-sleeping thread has no effect.
- R8: An interrupt wakes the thread it targets. From low power, intr[0] gives single-thread-0, intr[1] gives single-thread-1 and both give multi-thread. In a single-thread mode, an interrupt to the sleeping thread returns to multi-thread. An interrupt to an awake thread has no effect.
- R9: In low power no grant is issued, halts are ignored, and the turn is reset to thread 0, so the first contested grant after waking goes to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | 2 | Per-thread micro-op queue empty flag |
| occ0 | input | CNT_W (6) | Buffer entries held by thread 0 |
| occ1 | input | CNT_W (6) | Buffer entries held by thread 1 |
| halt | input | 2 | Per-thread halt event pulse |
| intr | input | 2 | Per-thread interrupt event pulse |
| grant | output | 2 | Allocation grant |
| mode | output | 2 | Current threading mode |
| limit0 | output | CNT_W (6) | Entry limit for thread 0 |
| limit1 | output | CNT_W (6) | Entry limit for thread 1 |

## Verification
The checker tests on every cycle that the grant has at most one bit set and goes only to a thread whose inputs make it eligible. It also tests that two back-to-back contested cycles alternate, that the multi-thread limits are half the buffer, that low power never grants, and that a lone thread-1 halt in multi-thread mode and any interrupt in low power change the mode. The bench scenarios cover the rest: the full halt and interrupt tour through every mode, limits that sit exactly at the boundary, halts ignored in low power, and the turn reset that shows up only in the first contested grant after waking.

// File: rtl/alloc_arb_pkg.sv
package alloc_arb_pkg;

  typedef enum logic [1:0] {
    MODE_MT  = 2'd0,
    MODE_ST0 = 2'd1,
    MODE_ST1 = 2'd2,
    MODE_LOW = 2'd3
  } thr_mode_e;

  // Awake-thread set for a mode: bit t set when thread t runs.
  function automatic logic [1:0] mode_awake(thr_mode_e m);
    case (m)
      MODE_MT:  return 2'b11;
      MODE_ST0: return 2'b01;
      MODE_ST1: return 2'b10;
      default:  return 2'b00;
    endcase
  endfunction

  function automatic thr_mode_e awake_mode(logic [1:0] a);
    case (a)
      2'b11:   return MODE_MT;
      2'b01:   return MODE_ST0;
      2'b10:   return MODE_ST1;
      default: return MODE_LOW;
    endcase
  endfunction

endpackage

// File: rtl/thread_mode_fsm.sv
module thread_mode_fsm
  import alloc_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] halt,
  input  logic [1:0] intr,
  output thr_mode_e  mode_q,
  output logic [1:0] awake
);

  logic [1:0] awake_d;
  thr_mode_e  mode_d;
  logic       mode_en;

  always_comb begin
    awake   = mode_awake(mode_q);
    // An interrupt wins over a halt aimed at the same thread.
    awake_d = (awake & ~halt) | intr;
    mode_d  = awake_mode(awake_d);
    mode_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_MT;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/partition_limits.sv
module partition_limits #(
  parameter int ENTRIES = 32,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic [1:0]            awake,
  output logic [1:0][CNT_W-1:0] limit
);

  localparam logic [CNT_W-1:0] LIM_ALL  = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(ENTRIES / 2);

  logic both_awake;
  assign both_awake = &awake;

  for (genvar t = 0; t < 2; t++) begin : g_lim
    always_comb begin
      if (!awake[t])       limit[t] = '0;
      else if (both_awake) limit[t] = LIM_HALF;
      else                 limit[t] = LIM_ALL;
    end
  end

endmodule

// File: rtl/alloc_pick.sv
module alloc_pick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] elig,
  input  logic       park,
  output logic [1:0] grant
);

  logic turn_q;
  logic turn_d;
  logic turn_en;

  always_comb begin
    if (&elig) grant = turn_q ? 2'b10 : 2'b01;
    else       grant = elig;
  end

  always_comb begin
    turn_en = park | (|grant);
    if (park)          turn_d = 1'b0;
    else if (grant[0]) turn_d = 1'b1;
    else               turn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= 1'b0;
    end else if (turn_en) begin
      turn_q <= turn_d;
    end
  end

endmodule

// File: rtl/thread_alloc_arb.sv
module thread_alloc_arb
  import alloc_arb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       q_empty,
  input  logic [CNT_W-1:0] occ0,
  input  logic [CNT_W-1:0] occ1,
  input  logic [1:0]       halt,
  input  logic [1:0]       intr,
  output logic [1:0]       grant,
  output logic [1:0]       mode,
  output logic [CNT_W-1:0] limit0,
  output logic [CNT_W-1:0] limit1
);

  thr_mode_e             mode_q;
  logic [1:0]            awake;
  logic [1:0][CNT_W-1:0] limit;
  logic [1:0][CNT_W-1:0] occ;
  logic [1:0]            elig;

  assign occ = {occ1, occ0};

  thread_mode_fsm u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt   (halt),
    .intr   (intr),
    .mode_q (mode_q),
    .awake  (awake)
  );

  partition_limits #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_lim (
    .awake (awake),
    .limit (limit)
  );

  for (genvar t = 0; t < 2; t++) begin : g_elig
    assign elig[t] = !q_empty[t] && awake[t] && (occ[t] < limit[t]);
  end

  alloc_pick u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .park  (mode_q == MODE_LOW),
    .grant (grant)
  );

  assign mode   = mode_q;
  assign limit0 = limit[0];
  assign limit1 = limit[1];

endmodule

// File: rtl/thread_alloc_arb_chk.sv
module thread_alloc_arb_chk #(
  parameter int ENTRIES = 32,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       q_empty,
  input logic [CNT_W-1:0] occ0,
  input logic [CNT_W-1:0] occ1,
  input logic [1:0]       halt,
  input logic [1:0]       intr,
  input logic [1:0]       grant,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] limit0,
  input logic [CNT_W-1:0] limit1
);

  logic [1:0] up;
  logic       e0, e1;

  assign up = (mode == 2'd0) ? 2'b11 : (mode == 2'd1) ? 2'b01 :
              (mode == 2'd2) ? 2'b10 : 2'b00;
  assign e0 = !q_empty[0] && up[0] && (occ0 < limit0);
  assign e1 = !q_empty[1] && up[1] && (occ1 < limit1);

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[0] |-> e0) and (grant[1] |-> e1));

  // R3
  grant_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[0] && e0 && e1) |=> (!(e0 && e1) || grant[1]));

  // R4
  half_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (limit0 == CNT_W'(ENTRIES / 2) && limit1 == CNT_W'(ENTRIES / 2)));

  // R6
  halt_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && halt == 2'b10 && intr == 2'b00) |=> (mode == 2'd1));

  // R8
  wake_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && intr != 2'b00) |=> (mode != 2'd3));

  // R9
  low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (grant == 2'b00));

endmodule

bind thread_alloc_arb thread_alloc_arb_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .q_empty (q_empty),
  .occ0    (occ0),
  .occ1    (occ1),
  .halt    (halt),
  .intr    (intr),
  .grant   (grant),
  .mode    (mode),
  .limit0  (limit0),
  .limit1  (limit1)
);

// File: tb/thread_alloc_arb_bench.sv
module thread_alloc_arb_bench;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   q_empty = 2'b11;
  logic [W-1:0] occ0 = '0, occ1 = '0;
  logic [1:0]   halt = '0, intr = '0;
  logic [1:0]   grant, mode;
  logic [W-1:0] limit0, limit1;

  always #10 clk = ~clk;

  thread_alloc_arb u_thread_alloc_arb (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .occ0(occ0), .occ1(occ1),
    .halt(halt), .intr(intr), .grant(grant), .mode(mode),
    .limit0(limit0), .limit1(limit1)
  );

  typedef struct {
    logic [1:0]   g;
    logic [1:0]   m;
    logic [W-1:0] l0;
    logic [W-1:0] l1;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: apply one cycle of stimulus and queue the expected outputs.
  task automatic step(input logic [1:0] qe, input logic [W-1:0] o0, input logic [W-1:0] o1,
                      input logic [1:0] h, input logic [1:0] i,
                      input logic [1:0] eg, input logic [1:0] em,
                      input logic [W-1:0] el0, input logic [W-1:0] el1, input string tag);
    exp_t e;
    @(negedge clk);
    q_empty = qe; occ0 = o0; occ1 = o1; halt = h; intr = i;
    e.g = eg; e.m = em; e.l0 = el0; e.l1 = el1; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare mid-low-phase, away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (grant !== e.g || mode !== e.m || limit0 !== e.l0 || limit1 !== e.l1) begin
          errors++;
          $display("FAIL %s: grant=%b mode=%0d lim=%0d/%0d expected grant=%b mode=%0d lim=%0d/%0d",
                   e.tag, grant, mode, limit0, limit1, e.g, e.m, e.l0, e.l1);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    qe     o0  o1  halt   intr   grant  mode  l0  l1  tag
    step(2'b11, 0,  0,  2'b00, 2'b00, 2'b00, 2'd0, 16, 16, "R5 reset state / R2 empty queues");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R3 first contested grant to thread 0");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b10, 2'd0, 16, 16, "R3 alternate to thread 1");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R3 alternate to thread 0");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b10, 2'd0, 16, 16, "R3 alternate to thread 1 again");
    step(2'b10, 0,  0,  2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R2 thread 1 queue empty");
    step(2'b10, 0,  0,  2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R3 fallback to thread 0 on thread 1 turn");
    step(2'b00, 0,  16, 2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R2 thread 1 at half limit is full");
    step(2'b00, 16, 15, 2'b00, 2'b00, 2'b10, 2'd0, 16, 16, "R2 thread 0 full, thread 1 below limit");
    step(2'b00, 0,  0,  2'b10, 2'b00, 2'b01, 2'd0, 16, 16, "R5 halt not yet visible");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b01, 2'd1, 32, 0,  "R6 halt by thread 1 gives single-thread-0");
    step(2'b00, 20, 0,  2'b00, 2'b00, 2'b01, 2'd1, 32, 0,  "R4 single thread uses beyond half");
    step(2'b00, 32, 0,  2'b00, 2'b00, 2'b00, 2'd1, 32, 0,  "R2 single thread at full limit");
    step(2'b00, 0,  0,  2'b00, 2'b10, 2'b01, 2'd1, 32, 0,  "R8 interrupt to sleeping thread 1");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b10, 2'd0, 16, 16, "R8 back in multi-thread, turn at thread 1");
    step(2'b00, 0,  0,  2'b01, 2'b00, 2'b01, 2'd0, 16, 16, "R6 halt by thread 0 issued");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b10, 2'd2, 0,  32, "R6 single-thread-1 after thread 0 halt");
    step(2'b00, 0,  0,  2'b10, 2'b00, 2'b10, 2'd2, 0,  32, "R7 awake thread 1 halts");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b00, 2'd3, 0,  0,  "R7 low power entered / R4 zero limits");
    step(2'b00, 0,  0,  2'b11, 2'b00, 2'b00, 2'd3, 0,  0,  "R9 halts in low power");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b00, 2'd3, 0,  0,  "R9 halts ignored, still low power");
    step(2'b00, 0,  0,  2'b00, 2'b10, 2'b00, 2'd3, 0,  0,  "R9 no grant while interrupt pending");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b10, 2'd2, 0,  32, "R8 interrupt 1 wakes into single-thread-1");
    step(2'b00, 0,  0,  2'b01, 2'b11, 2'b10, 2'd2, 0,  32, "R8 interrupt beats halt on thread 0");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R8 both awake, turn at thread 0");
    step(2'b11, 0,  0,  2'b11, 2'b00, 2'b00, 2'd0, 16, 16, "R3 no grant holds turn at thread 1");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b00, 2'd3, 0,  0,  "R6 both halts give low power");
    step(2'b00, 0,  0,  2'b00, 2'b11, 2'b00, 2'd3, 0,  0,  "R9 low power, wake both");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b01, 2'd0, 16, 16, "R9 turn reset to thread 0 after low power");
    step(2'b00, 0,  0,  2'b00, 2'b00, 2'b10, 2'd0, 16, 16, "R1 single bit grant to thread 1");
    @(negedge clk);
    @(negedge clk);
    #10;
    done = 1;
    report();
  end

endmodule